// File: doc/BRIEF.md
# Tri-level PWM gate sequencer

This block sequences the two gate commands of a synchronous buck power stage: the high-side switch and the low-side switch. Its PWM input has already been sorted into three digital levels (high, mid, low). A zero-cross flag reports whether inductor current is positive. Two sense flags report whether each switch has actually turned off, and a global enable can turn the stage off.

Each PWM level maps to a target:
- In the high level the high-side switch conducts.
- In the low level the low-side switch conducts.
- In the mid band the low-side switch conducts only while inductor current is positive. Otherwise both switches stay off, which emulates a diode on the low side.

Dead time adapts to the real switch. Before a gate is turned on, the block first withdraws the opposite gate. It then waits until that switch is sensed off, and then counts a programmable number of clock cycles. All inputs are synchronous digital flags. Both gate commands are registered.

Top module: `gate_seq`

## Requirements
- R1: With enable high and `pwm_lvl` equal to 2'b10 or 2'b11 (high level), the sequence ends with `hs_gate`=1 and `ls_gate`=0.
- R2: With enable high and `pwm_lvl`=2'b00 (low level), the sequence ends with `ls_gate`=1 and `hs_gate`=0.
- R3: With enable high, `pwm_lvl`=2'b01 (mid band) and `zc_pos`=1, the sequence ends with `ls_gate`=1 and `hs_gate`=0.
- R4: With enable high, `pwm_lvl`=2'b01 and `zc_pos`=0, both gates are 0 after the next clock edge.
- R5: Whenever the target is the high side, `ls_gate` is 0 after the next edge. `hs_gate` rises at the DEAD_CYC-th consecutive qualifying edge. A qualifying edge is one where the target was also the high side at the previous edge, `ls_gate` is 0 and `ls_off`=1. An edge that does not qualify sets the count back to zero.
- R6: Whenever the target is the low side, `hs_gate` is 0 after the next edge. `ls_gate` rises at the DEAD_CYC-th consecutive qualifying edge. A qualifying edge is one where the target was also the low side at the previous edge, `hs_gate` is 0 and `hs_off`=1. A non-qualifying edge sets the count back to zero.
- R7: With `en`=0, both gates are 0 after the next clock edge, whatever the other inputs are.
- R8: `hs_gate` and `ls_gate` are never 1 in the same cycle.
- R9: When the target changes, the dead-time count starts again from zero, beginning from the current gate state.
- R10: While `rst_n`=0 at a clock edge, both gates are 0 after that edge, and the sequencer holds no target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Stage enable; 0 forces both gates off |
| pwm_lvl | input | 2 | Classified PWM: 00 low, 01 mid, 1x high |
| zc_pos | input | 1 | 1 when inductor current is positive |
| hs_off | input | 1 | High-side switch sensed off |
| ls_off | input | 1 | Low-side switch sensed off |
| hs_gate | output | 1 | High-side gate command |
| ls_gate | output | 1 | Low-side gate command |

## Verification
The turn-on assertions assume that a sense flag reads off only when its gate command is off. The bench stimulus keeps to this by a plant model: after each edge it sets each sense flag to the inverse of that gate, and it can randomly hold a flag at "still on" to stretch the dead time. PWM levels, the zero-cross flag, enable and reset change at random, and each level is held for a random number of cycles. This mixes sequences that finish with sequences cut off part-way. Directed cases pin down the exact turn-on cycle, a stalled sense flag, and a restart in the middle of a sequence.

// File: rtl/gate_seq.sv
module gate_seq #(
  parameter int DEAD_CYC = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic [1:0] pwm_lvl,
  input  logic       zc_pos,
  input  logic       hs_off,
  input  logic       ls_off,
  output logic       hs_gate,
  output logic       ls_gate
);
  localparam int CW = (DEAD_CYC < 2) ? 1 : $clog2(DEAD_CYC);
  localparam logic [CW-1:0] LAST = CW'(DEAD_CYC - 1);

  typedef enum logic [1:0] {T_NONE, T_LS, T_HS} tgt_t;

  tgt_t tgt, tgt_q;
  logic hs_q, ls_q;
  logic [CW-1:0] cnt;
  logic same;

  always_comb begin
    if (!en)            tgt = T_NONE;
    else if (pwm_lvl[1]) tgt = T_HS;
    else if (pwm_lvl[0]) tgt = zc_pos ? T_LS : T_NONE;
    else                 tgt = T_LS;
  end

  assign same = (tgt == tgt_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tgt_q <= T_NONE;
      hs_q  <= 1'b0;
      ls_q  <= 1'b0;
      cnt   <= '0;
    end else begin
      tgt_q <= tgt;
      case (tgt)
        T_HS: begin
          ls_q <= 1'b0;
          if (!hs_q) begin
            if (same && !ls_q && ls_off) begin
              if (cnt == LAST) begin
                hs_q <= 1'b1;
                cnt  <= '0;
              end else cnt <= cnt + 1'b1;
            end else cnt <= '0;
          end
        end
        T_LS: begin
          hs_q <= 1'b0;
          if (!ls_q) begin
            if (same && !hs_q && hs_off) begin
              if (cnt == LAST) begin
                ls_q <= 1'b1;
                cnt  <= '0;
              end else cnt <= cnt + 1'b1;
            end else cnt <= '0;
          end
        end
        default: begin
          hs_q <= 1'b0;
          ls_q <= 1'b0;
          cnt  <= '0;
        end
      endcase
    end
  end

  assign hs_gate = hs_q;
  assign ls_gate = ls_q;
endmodule

module gate_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       en,
  input logic [1:0] pwm_lvl,
  input logic       zc_pos,
  input logic       hs_off,
  input logic       ls_off,
  input logic       hs_gate,
  input logic       ls_gate
);
  // R8
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_gate && ls_gate));
  // R7
  en_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!hs_gate && !ls_gate));
  // R4
  mid_neg_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && pwm_lvl == 2'b01 && !zc_pos) |=> (!hs_gate && !ls_gate));
  // R5
  hs_release_ls_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && pwm_lvl[1]) |=> !ls_gate);
  // R6
  ls_release_hs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && pwm_lvl == 2'b00) |=> !hs_gate);
  // R5
  hs_after_sense_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_gate) |-> ($past(ls_off) && !$past(ls_gate)));
  // R6
  ls_after_sense_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ls_gate) |-> ($past(hs_off) && !$past(hs_gate)));
endmodule

bind gate_seq gate_seq_chk u_chk (.*);

// File: tb/tb_gate_seq.sv
`timescale 1ns/1ps
module tb_gate_seq;
  localparam int D = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0, en = 1'b0, zc_pos = 1'b0, hs_off = 1'b1, ls_off = 1'b1;
  logic [1:0] pwm_lvl = 2'b00;
  logic hs_gate, ls_gate;
  logic stall_h = 1'b0, stall_l = 1'b0;
  int vecs = 0, errs = 0;
  bit done = 0;

  gate_seq #(.DEAD_CYC(D)) dut (.*);

  always #2.5 clk = ~clk;

  // reference model state: target 0 none, 1 low side, 2 high side
  int m_tgt = 0, m_cnt = 0;
  logic m_hs = 0, m_ls = 0;
  string tag = "R10";

  function automatic int tgt_of(logic e, logic [1:0] l, logic z);
    if (!e) return 0;
    if (l[1]) return 2;
    if (l[0]) return z ? 1 : 0;
    return 1;
  endfunction

  function automatic string tag_of(logic r, logic e, logic [1:0] l, logic z, bit chg);
    if (!r) return "R10";
    if (!e) return "R7";
    if (chg) return "R9";
    if (l[1]) return "R1/R5";
    if (l == 2'b01) return z ? "R3/R6" : "R4";
    return "R2/R6";
  endfunction

  always @(posedge clk) begin
    int t;
    t = tgt_of(en, pwm_lvl, zc_pos);
    tag = tag_of(rst_n, en, pwm_lvl, zc_pos, t != m_tgt);
    if (!rst_n) begin
      m_tgt = 0; m_cnt = 0; m_hs = 0; m_ls = 0;
    end else begin
      if (t == 2) begin
        if (!m_hs) begin
          if (t == m_tgt && !m_ls && ls_off) begin
            if (m_cnt == D - 1) begin m_hs = 1; m_cnt = 0; end else m_cnt++;
          end else m_cnt = 0;
        end
        m_ls = 0;
      end else if (t == 1) begin
        if (!m_ls) begin
          if (t == m_tgt && !m_hs && hs_off) begin
            if (m_cnt == D - 1) begin m_ls = 1; m_cnt = 0; end else m_cnt++;
          end else m_cnt = 0;
        end
        m_hs = 0;
      end else begin
        m_hs = 0; m_ls = 0; m_cnt = 0;
      end
      m_tgt = t;
    end
  end

  task automatic chk(string req, logic gh, logic gl, logic eh, logic el);
    vecs++;
    if (gh !== eh || gl !== el) begin
      errs++;
      $display("FAIL %s: hs_gate=%b ls_gate=%b expected hs_gate=%b ls_gate=%b",
               req, gh, gl, eh, el);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    chk(tag, hs_gate, ls_gate, m_hs, m_ls);
    vecs++;
    if (hs_gate && ls_gate) begin
      errs++;
      $display("FAIL R8: hs_gate=1 ls_gate=1 expected not both 1");
    end
    hs_off = stall_h ? 1'b0 : !hs_gate;
    ls_off = stall_l ? 1'b0 : !ls_gate;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errs++;
      $display("FAIL watchdog: run not finished, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    // R10 reset state
    en = 1; pwm_lvl = 2'b10;
    repeat (3) tick();
    chk("R10", hs_gate, ls_gate, 0, 0);
    rst_n = 1;

    // R2 / R6: low level, ls turns on at edge D+1
    pwm_lvl = 2'b00;
    for (int i = 1; i <= D + 1; i++) begin
      tick();
      chk("R2/R6", hs_gate, ls_gate, 0, i == D + 1);
    end

    // R1 / R5: high level, ls released at edge 1, hs on at edge D+1
    pwm_lvl = 2'b10;
    for (int i = 1; i <= D + 1; i++) begin
      tick();
      chk("R1/R5", hs_gate, ls_gate, i == D + 1, 0);
    end

    // R6: stalled high-side sense holds ls off
    pwm_lvl = 2'b00; stall_h = 1;
    for (int i = 0; i < 10; i++) begin
      tick();
      chk("R6 stall", hs_gate, ls_gate, 0, 0);
    end
    stall_h = 0; hs_off = 1;
    for (int i = 1; i <= D; i++) begin
      tick();
      chk("R6 release", hs_gate, ls_gate, 0, i == D);
    end

    // R9: switch to high, then back to low mid-sequence, then high again
    pwm_lvl = 2'b10;
    tick(); tick();
    chk("R9", hs_gate, ls_gate, 0, 0);
    pwm_lvl = 2'b00;
    tick();
    chk("R9", hs_gate, ls_gate, 0, 0);
    pwm_lvl = 2'b11;
    for (int i = 1; i <= D + 1; i++) begin
      tick();
      chk("R9 restart", hs_gate, ls_gate, i == D + 1, 0);
    end

    // R4: mid band, negative current: both off next edge
    pwm_lvl = 2'b01; zc_pos = 0;
    tick();
    chk("R4", hs_gate, ls_gate, 0, 0);
    tick();
    chk("R4", hs_gate, ls_gate, 0, 0);

    // R3: mid band, positive current
    zc_pos = 1;
    for (int i = 1; i <= D + 1; i++) begin
      tick();
      chk("R3", hs_gate, ls_gate, 0, i == D + 1);
    end

    // R7: enable low
    en = 0; pwm_lvl = 2'b10;
    for (int i = 0; i < 6; i++) begin
      tick();
      chk("R7", hs_gate, ls_gate, 0, 0);
    end
    en = 1;

    // constrained random
    for (int n = 0; n < 600; n++) begin
      int hold;
      pwm_lvl = 2'($urandom_range(0, 3));
      zc_pos  = 1'($urandom_range(0, 1));
      en      = ($urandom_range(0, 15) != 0);
      rst_n   = ($urandom_range(0, 63) != 0);
      hold = $urandom_range(1, 2 * D + 4);
      for (int k = 0; k < hold; k++) begin
        stall_h = ($urandom_range(0, 3) == 0);
        stall_l = ($urandom_range(0, 3) == 0);
        tick();
        rst_n = 1;
      end
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule